// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how fast a fan turns. It counts slow reference ticks between the first and the fifth transition of the fan's tachometer line. Five transitions make two tach pulses, which is one revolution, so the count is the time one revolution takes in tick units. A parameterized prescaler divides the system clock down to the tick rate. With the defaults (CLK_DIV = 1111 on a 100 MHz clock) the tick rate is about 90 kHz, so one tick is roughly 11.1 µs. The tach input is asynchronous. It is synchronized, and both its rising and its falling edges count.

The measurement runs continuously. The transition that closes one window also opens the next. Each finished result goes into a holding register, so a host that reads the low and the high byte gets the two halves of the same count while the next window is being timed.

A fan that has stopped is reported as stalled, with a count of all ones, and is never reported as a speed. Two things cause this: too many ticks pass without a tach transition, or the count would reach its ceiling.

The window controller has two states:
- ST_ARM waits for an opening transition. An edge moves it to ST_COUNT. A timeout publishes a stall and it stays in ST_ARM.
- In ST_COUNT, the fifth edge publishes the count and the state stays in ST_COUNT with a new window opened. A timeout or saturation publishes a stall and returns it to ST_ARM.

Top module: `fan_tach_meter`

## Requirements
- R1: While reset is asserted and right after it, both result bytes read 0x00, `stall` is 0 and `result_strobe` is 0.
- R2: A tach level change present at clock edge n is handled as one measurement edge at clock edge n+2, whichever its direction. Changes one cycle apart each count.
- R3: A tick is consumed at each clock edge whose number, counted from the first edge after reset release, is a multiple of CLK_DIV.
- R4: A published count equals the number of ticks consumed after the window's opening edge, up to and including the fifth edge. A tick at the opening edge is excluded. A tick at the fifth edge is included.
- R5: The fifth edge of a window is also the opening edge of the next window, so results follow back to back.
- R6: A result is stored at the clock edge that closes its window. `result_strobe` is high for exactly the following cycle.
- R7: `rd_data` returns count bits 7:0 when `rd_idx` equals BASE_IDX and bits 15:8 at BASE_IDX+1. Any other index returns 0x00.
- R8: If TIMEOUT_TICKS ticks are consumed since the last edge (or since reset, or since the previous timeout) with no edge, a stall is published: `stall` = 1 and count = 0xFFFF. The open window is dropped, and the next edge opens a new window. An edge in the same cycle as that last tick prevents the timeout.
- R9: If the tick count of an open window would reach 0xFFFF, a stall is published in that cycle with count 0xFFFF. This happens even if a fifth edge arrives in the same cycle.
- R10: The stored count and `stall` change only at a publication. A good result clears `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | 1 | Asynchronous fan tachometer line |
| rd_idx | input | IDX_W | Register index for the byte read |
| rd_data | output | 8 | Selected byte of the held count |
| result_strobe | output | 1 | One-cycle pulse after a result is stored |
| stall | output | 1 | Held result reports a stalled fan |

## Verification
A tick and a tach edge can land in the same clock cycle. The window rules decide whether that tick belongs to the count, so this coincidence is the main collision. The bench places opening and closing edges exactly on tick cycles, using the fixed two-edge synchronizer latency, and compares each result with a count worked out from tick-cycle arithmetic. A second collision is between the last timeout tick and an arriving edge. One window puts the edge on precisely the TIMEOUT-th tick, and the bench expects a normal result with no stall. Every stored result is also checked for the clock cycle in which it appears.

// File: rtl/fantach_pkg.sv
package fantach_pkg;
    typedef enum logic {
        ST_ARM   = 1'b0,
        ST_COUNT = 1'b1
    } meas_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tach_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // either direction of a settled level change is one edge
    assign edge_pulse = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int CLK_DIV = 1111
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_DIV <= 1) begin : g_pass
            assign tick = rst_n;
        end else begin : g_div
            localparam int DIV_W = $clog2(CLK_DIV);
            logic [DIV_W-1:0] div_q;

            assign tick = (div_q == DIV_W'(CLK_DIV - 1));

            always_ff @(posedge clk) begin
                if (!rst_n)    div_q <= '0;
                else if (tick) div_q <= '0;
                else           div_q <= div_q + 1'b1;
            end

            // R3: ticks are isolated single-cycle pulses
            p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tach_window_fsm.sv
module tach_window_fsm
    import fantach_pkg::*;
#(
    parameter int MEAS_EDGES    = 5,
    parameter int CNT_W         = 16,
    parameter int TIMEOUT_TICKS = 45000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             edge_pulse,
    output logic             pub_valid,
    output logic [CNT_W-1:0] pub_count,
    output logic             pub_stall
);
    localparam int EDGE_W = $clog2(MEAS_EDGES);
    localparam int IDLE_W = $clog2(TIMEOUT_TICKS);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - 1'b1;

    meas_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [EDGE_W-1:0] edge_n_q, edge_n_d;
    logic [IDLE_W-1:0] idle_q, idle_d;

    logic timeout, saturate, last_edge;
    logic [CNT_W-1:0] cnt_inc;

    assign timeout   = tick && !edge_pulse && (idle_q == IDLE_W'(TIMEOUT_TICKS - 1));
    assign saturate  = tick && (cnt_q == CNT_NEAR);
    assign last_edge = (edge_n_q == EDGE_W'(MEAS_EDGES - 1));
    assign cnt_inc   = tick ? cnt_q + 1'b1 : cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ARM;
            cnt_q    <= '0;
            edge_n_q <= '0;
            idle_q   <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            edge_n_q <= edge_n_d;
            idle_q   <= idle_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        edge_n_d  = edge_n_q;
        pub_valid = 1'b0;
        pub_count = CNT_MAX;
        pub_stall = 1'b0;

        if (edge_pulse)   idle_d = '0;
        else if (timeout) idle_d = '0;
        else if (tick)    idle_d = idle_q + 1'b1;
        else              idle_d = idle_q;

        unique case (state_q)
            ST_ARM: begin
                if (edge_pulse) begin
                    state_d  = ST_COUNT;
                    cnt_d    = '0;
                    edge_n_d = EDGE_W'(1);
                end else if (timeout) begin
                    pub_valid = 1'b1;
                    pub_stall = 1'b1;
                end
            end
            ST_COUNT: begin
                if (saturate) begin
                    pub_valid = 1'b1;
                    pub_stall = 1'b1;
                    state_d   = ST_ARM;
                    cnt_d     = '0;
                    edge_n_d  = '0;
                end else if (edge_pulse && last_edge) begin
                    pub_valid = 1'b1;
                    pub_count = cnt_inc;
                    cnt_d     = '0;
                    edge_n_d  = EDGE_W'(1);
                end else if (edge_pulse) begin
                    cnt_d    = cnt_inc;
                    edge_n_d = edge_n_q + 1'b1;
                end else if (timeout) begin
                    pub_valid = 1'b1;
                    pub_stall = 1'b1;
                    state_d   = ST_ARM;
                    cnt_d     = '0;
                    edge_n_d  = '0;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            default: state_d = ST_ARM;
        endcase
    end

    // R4: an undisturbed tick advances the window count by one
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick && !edge_pulse && cnt_q != CNT_NEAR && !timeout)
        |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R5: an open window always holds between one and MEAS_EDGES-1 edges
    p_edge_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (edge_n_q != '0 && edge_n_q <= EDGE_W'(MEAS_EDGES - 1)));

    // R8: the idle tick count never passes the timeout limit
    p_idle_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q <= IDLE_W'(TIMEOUT_TICKS - 1));
endmodule

// File: rtl/tach_result_regs.sv
module tach_result_regs
    import fantach_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int IDX_W    = 8,
    parameter int BASE_IDX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pub_valid,
    input  logic [CNT_W-1:0]  pub_count,
    input  logic              pub_stall,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              result_strobe,
    output logic              stall
);
    localparam int NBYTES = (CNT_W + BYTE_W - 1) / BYTE_W;

    logic [CNT_W-1:0]         hold_q;
    logic [NBYTES*BYTE_W-1:0] hold_wide;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q        <= '0;
            stall         <= 1'b0;
            result_strobe <= 1'b0;
        end else begin
            result_strobe <= pub_valid;
            if (pub_valid) begin
                hold_q <= pub_count;
                stall  <= pub_stall;
            end
        end
    end

    assign hold_wide = (NBYTES*BYTE_W)'(hold_q);

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (rd_idx == IDX_W'(BASE_IDX + b)) rd_data = hold_wide[b*BYTE_W +: BYTE_W];
        end
    end

    // R9: a stalled result always carries the full-scale count
    p_stall_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (&hold_q));

    // R10: the held count moves only after a publication
    p_hold_publish_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_q) |-> $past(pub_valid));
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fantach_pkg::*;
#(
    parameter int CLK_DIV       = 1111,
    parameter int MEAS_EDGES    = 5,
    parameter int CNT_W         = 16,
    parameter int TIMEOUT_TICKS = 45000,
    parameter int IDX_W         = 8,
    parameter int BASE_IDX      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_in,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             result_strobe,
    output logic             stall
);
    logic             edge_pulse, tick, pub_valid, pub_stall;
    logic [CNT_W-1:0] pub_count;

    tach_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .edge_pulse(edge_pulse)
    );

    tick_prescaler #(.CLK_DIV(CLK_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    tach_window_fsm #(
        .MEAS_EDGES(MEAS_EDGES), .CNT_W(CNT_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .edge_pulse(edge_pulse),
        .pub_valid(pub_valid), .pub_count(pub_count), .pub_stall(pub_stall)
    );

    tach_result_regs #(
        .CNT_W(CNT_W), .IDX_W(IDX_W), .BASE_IDX(BASE_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .pub_valid(pub_valid), .pub_count(pub_count),
        .pub_stall(pub_stall), .rd_idx(rd_idx), .rd_data(rd_data),
        .result_strobe(result_strobe), .stall(stall)
    );
endmodule

// File: tb/sim_fan_tach_meter.sv
`timescale 1ns/1ps
module sim_fan_tach_meter;
    localparam int DIV0  = 4;
    localparam int TO0   = 50;
    localparam int BASE  = 16;

    typedef struct {
        int          cyc;
        logic [15:0] cnt;
        logic        stl;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tach0 = 1'b0, tach1 = 1'b0;
    logic [7:0] idx0 = 8'(BASE), idx1 = 8'(BASE);
    logic [7:0] data0, data1;
    logic       strobe0, strobe1, stall0, stall1;

    int  cyc = 0;
    int  checks = 0, fails = 0;
    bit  mon_on = 1'b1;
    bit  finished = 1'b0;
    exp_t q[$];
    int  win_first = 0, win_n = 0;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    fan_tach_meter #(.CLK_DIV(DIV0), .TIMEOUT_TICKS(TO0), .BASE_IDX(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .tach_in(tach0), .rd_idx(idx0), .rd_data(data0),
        .result_strobe(strobe0), .stall(stall0)
    );

    // second instance: tick every clock, long timeout, for the saturation case
    fan_tach_meter #(.CLK_DIV(1), .TIMEOUT_TICKS(20000), .BASE_IDX(BASE)) u1 (
        .clk(clk), .rst_n(rst_n), .tach_in(tach1), .rd_idx(idx1), .rd_data(data1),
        .result_strobe(strobe1), .stall(stall1)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rd0(input int i, output logic [7:0] d);
        idx0 = 8'(i);
        #1 d = data0;
    endtask

    // R2: a change driven after edge n is handled at edge n+2 -> event edge E = n+3
    task automatic edge0_at(input int e, input string tag);
        while (cyc != e - 3) @(negedge clk);
        tach0 = ~tach0;
        if (win_n == 0) begin
            win_first = e; win_n = 1;
        end else begin
            win_n++;
            if (win_n == 5) begin
                // R3/R4: ticks sit on multiples of DIV0; opening tick excluded, closing included
                q.push_back('{e, 16'(e / DIV0 - win_first / DIV0), 1'b0, tag});
                win_first = e; win_n = 1;   // R5: closing edge opens the next window
            end
        end
    endtask

    task automatic expect_stall0(input int t, input string tag);
        q.push_back('{t, 16'hFFFF, 1'b1, tag});
        win_n = 0;
    endtask

    // scoreboard monitor
    initial begin
        logic [7:0] lo, hi, other;
        exp_t e;
        forever begin
            @(negedge clk);
            if (mon_on && rst_n && strobe0) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected result strobe cycle", cyc, 0);
                end else begin
                    e = q.pop_front();
                    chk(cyc == e.cyc, "R6", {e.tag, " result cycle"}, cyc, e.cyc);
                    rd0(BASE, lo);
                    rd0(BASE + 1, hi);
                    rd0(BASE + 2, other);
                    chk(lo == e.cnt[7:0], "R7", {e.tag, " low byte"}, lo, e.cnt[7:0]);
                    chk(hi == e.cnt[15:8], "R7", {e.tag, " high byte"}, hi, e.cnt[15:8]);
                    chk(other == 8'h00, "R7", "unmapped index", other, 0);
                    chk(stall0 == e.stl, "R10", {e.tag, " stall flag"}, stall0, e.stl);
                    idx0 = 8'(BASE);
                end
            end
        end
    end

    task automatic run_u0();
        edge0_at(12, "R4");                 // W1: opening and closing edges on tick cycles
        edge0_at(32, "R4");
        edge0_at(52, "R4");
        edge0_at(72, "R4");
        edge0_at(92, "R4");
        edge0_at(99, "R2");                 // W2: uneven gaps
        edge0_at(108, "R2");
        edge0_at(121, "R2");
        edge0_at(151, "R2");
        edge0_at(152, "R5");                // W3: edges one cycle apart
        edge0_at(153, "R5");
        edge0_at(154, "R5");
        edge0_at(155, "R5");
        edge0_at(352, "R8 edge-wins");      // W4: edge on the TIMEOUT-th tick
        edge0_at(355, "R8 edge-wins");
        edge0_at(358, "R8 edge-wins");
        edge0_at(361, "R8 edge-wins");
        edge0_at(370, "R8");                // W5: window dropped by timeout
        expect_stall0(568, "R8 mid-window");
        edge0_at(600, "R10");
        edge0_at(640, "R10");
        edge0_at(680, "R10");
        edge0_at(720, "R10");
        edge0_at(760, "R10");               // good result clears stall
        expect_stall0(960, "R8 open-window");
        expect_stall0(1160, "R8 armed");
        wait (q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        mon_on = 1'b0;
    endtask

    task automatic drive1_at(input int e);
        while (cyc != e - 3) @(negedge clk);
        tach1 = ~tach1;
    endtask

    task automatic run_u1();
        logic [7:0] lo, hi;
        drive1_at(10);
        drive1_at(16510);
        drive1_at(33010);
        drive1_at(49510);
        @(negedge clk);
        while (!strobe1) @(negedge clk);
        chk(cyc == 65545, "R9", "saturation result cycle", cyc, 65545);
        chk(stall1 == 1'b1, "R9", "saturation stall flag", stall1, 1);
        idx1 = 8'(BASE);
        #1 lo = data1;
        idx1 = 8'(BASE + 1);
        #1 hi = data1;
        chk(lo == 8'hFF, "R9", "saturation low byte", lo, 8'hFF);
        chk(hi == 8'hFF, "R9", "saturation high byte", hi, 8'hFF);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rd0(BASE, d);
        chk(d == 8'h00, "R1", "reset low byte", d, 0);
        rd0(BASE + 1, d);
        chk(d == 8'h00, "R1", "reset high byte", d, 0);
        chk(stall0 == 1'b0, "R1", "reset stall", stall0, 0);
        chk(strobe0 == 1'b0, "R1", "reset strobe", strobe0, 0);
        idx0 = 8'(BASE);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(strobe0 == 1'b0 && stall0 == 1'b0, "R1", "state after release", {strobe0, stall0}, 0);
        fork
            run_u0();
            run_u1();
        join
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R6 watchdog expired actual=%0d expected=<200000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule